// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital half of an eight-input successive-approximation converter. Software programs a single control word that picks the input channels, the conversion clock divider, the resolution, the start source and an enable. The block derives a conversion clock from the peripheral clock and drives a one-hot channel select to the analog multiplexer. It presents trial codes to an external DAC and reads a single comparator bit back, one bit decision per conversion clock.

A conversion can be started by a software command, by a chosen edge on one of six external trigger inputs, or repeatedly in burst mode. Burst mode scans every selected channel from the lowest to the highest and then wraps. Each finished conversion is written into a result word that carries the value, the channel that produced it and a completion flag. Reading the result word clears that flag.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset the control word and the result word both read 0, `busy` is 0, `ch_sel` is 0 and `dac_code` is 0.
- R2: Control bits 15:8 hold a divider value D. A conversion lasts K*(D+1) peripheral clock cycles, where K is the clock count from R3. D = 0 runs the conversion clock at the peripheral clock rate.
- R3: Control bits 19:17 hold a resolution code c in 0..7. A conversion takes 11-c conversion clocks and resolves 10-c bits. One clock samples and each remaining clock decides one bit. The c lowest result bits read 0.
- R4: The trial code on `dac_code` is compared externally, and `cmp_in` = 1 means the input is at or above the trial code. The stored result equals the input value with its c low bits cleared.
- R5: The result word (address 1) has the done flag in bit 31, the channel number in bits 26:24 and the 10-bit result in bits 15:6. All other bits are 0. A finished conversion sets the flag, and a read of address 1 clears it without changing the other fields.
- R6: Control bits 26:24 are the start field. Writing 001 with bit 21 set starts one conversion of the lowest selected channel (bits 7:0). The start field reads back 000 once the conversion has begun.
- R7: A start field value m in 010..111 arms a conversion on `trig_in[m-2]`. With control bit 27 = 0 it fires on a rising edge, and with bit 27 = 1 on a falling edge. The opposite edge starts nothing and leaves the field armed.
- R8: With control bit 16 (burst) = 1 and a start field of 000, conversions run back to back. They visit the selected channels in ascending order and wrap from the highest to the lowest.
- R9: With burst = 1 and a non-zero start field, no automatic conversions run.
- R10: Control bit 21 = 0 holds the converter idle. A pending start field is kept, and a conversion already running is abandoned without setting the done flag.
- R11: `ch_sel` is one-hot for the channel being converted while `busy` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears done when reading address 1) |
| reg_addr | input | 1 | 0 = control word, 1 = result word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| trig_in | input | 6 | External trigger inputs, synchronous to `clk` |
| cmp_in | input | 1 | Comparator result for the current trial code |
| ch_sel | output | 8 | One-hot analog channel select |
| dac_code | output | 10 | Trial code for the external DAC |
| busy | output | 1 | A conversion is in progress |

## Verification
On every cycle the embedded properties guard several local rules. The channel select stays one-hot and, at the start of a conversion, points at a selected input. The divider never ticks twice in a row when D is non-zero, and the trial code changes only on conversion clocks. Unresolved low bits are zero, a start command clears itself, the done flag follows completions and reads, and a cleared enable stops the converter. Whole-conversion facts can only be shown by the bench's scenarios. These are the exact cycle count for each divider and resolution pair, the correct numeric result against a modelled comparator, and the scan order of burst mode. The same holds for ignoring the wrong trigger edge and keeping a start request pending while the converter is disabled.

// File: rtl/sar_pkg.sv
// Shared constants, field positions and helpers for the SAR conversion sequencer.
// Assumes eight channels and a 10-bit converter; field positions are fixed
// because software decodes them.
package sar_pkg;
    localparam int NUM_CH    = 8;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int RES_BITS  = 10;
    localparam int POS_W     = $clog2(RES_BITS);
    localparam int DIV_W     = 8;
    localparam int RESC_W    = 3;
    localparam int START_W   = 3;
    localparam int N_TRIG    = (1 << START_W) - 2;
    localparam int WORD_W    = 32;

    // control word fields
    localparam int SEL_LSB   = 0;
    localparam int DIV_LSB   = 8;
    localparam int BURST_BIT = 16;
    localparam int RESC_LSB  = 17;
    localparam int EN_BIT    = 21;
    localparam int START_LSB = 24;
    localparam int FALL_BIT  = 27;
    localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0F2F_FFFF;

    // result word fields
    localparam int DONE_BIT  = 31;
    localparam int CHF_LSB   = 24;
    localparam int RESF_LSB  = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_RESOLVE
    } eng_st_t;

    // First selected channel strictly after 'last', wrapping; 'last' itself if it is the only one.
    function automatic logic [CH_W-1:0] next_chan(input logic [NUM_CH-1:0] sel,
                                                  input logic [CH_W-1:0]   last);
        logic [CH_W-1:0] pick;
        logic [CH_W-1:0] idx;
        pick = last;
        for (int i = NUM_CH; i >= 1; i--) begin
            idx = last + CH_W'(i);
            if (sel[idx]) pick = idx;
        end
        return pick;
    endfunction
endpackage

// File: rtl/sar_clk_div.sv
// Conversion clock divider: emits a one-cycle tick every (div+1) cycles while run is high.
// Assumes the counter restarts from zero each time run rises, so every conversion
// begins phase-aligned.
module sar_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    // count peripheral cycles within one conversion clock period
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // R2: with a non-zero divider two ticks are never adjacent
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0) |=> !tick);
endmodule

// File: rtl/sar_trigger.sv
// External trigger edge detector: fires when the armed input shows the chosen edge.
// Assumes trigger inputs are already synchronous to clk. Mode values 2.. map to inputs 0..
module sar_trigger #(
    parameter int N_TRIG  = 6,
    parameter int START_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TRIG-1:0]  trig_in,
    input  logic [START_W-1:0] mode,
    input  logic               on_fall,
    output logic               fire
);
    logic [N_TRIG-1:0] prev_q;
    logic [N_TRIG-1:0] hit;

    // remember last input levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= trig_in;
    end

    for (genvar g = 0; g < N_TRIG; g++) begin : g_edge
        assign hit[g] = on_fall ? (prev_q[g] & ~trig_in[g]) : (~prev_q[g] & trig_in[g]);
    end

    // select the edge of the input armed by the mode field
    always_comb begin
        fire = 1'b0;
        for (int i = 0; i < N_TRIG; i++) begin
            if (mode == START_W'(i + 2)) fire = hit[i];
        end
    end
endmodule

// File: rtl/sar_bit_engine.sv
// Successive-approximation engine: one sample clock, then one bit decision per
// conversion clock from MSB down to the resolution limit.
// Assumes cmp_in is valid for the trial code presented during the current cycle.
module sar_bit_engine
    import sar_pkg::*;
#(
    parameter int RES   = RES_BITS,
    parameter int DW    = DIV_W,
    parameter int RW    = RESC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           conv_go,
    input  logic           abort,
    input  logic [DW-1:0]  div,
    input  logic [RW-1:0]  res_code,
    input  logic           cmp_in,
    output logic           busy,
    output logic [RES-1:0] dac_code,
    output logic           fin,
    output logic [RES-1:0] result
);
    localparam int PW = $clog2(RES);

    eng_st_t        st_q;
    logic [RES-1:0] code_q;
    logic [PW-1:0]  pos_q;
    logic [RW-1:0]  lsb_q;
    logic [DW-1:0]  div_q;
    logic           tick;
    logic [RES-1:0] resolved;
    logic [RES-1:0] trial_nxt;
    logic           last_bit;

    sar_clk_div #(.DIV_W(DW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (div_q),
        .tick (tick)
    );

    assign busy     = (st_q != ST_IDLE);
    assign dac_code = code_q;
    assign last_bit = (pos_q == PW'(lsb_q));
    assign fin      = (st_q == ST_RESOLVE) && tick && last_bit;
    assign result   = resolved;

    // decide the current bit and set the next trial bit
    always_comb begin
        resolved = code_q;
        if (!cmp_in) resolved[pos_q] = 1'b0;
        trial_nxt = resolved;
        if (pos_q != '0) trial_nxt[pos_q - 1'b1] = 1'b1;
    end

    // conversion state sequencing on conversion clock ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            code_q <= '0;
            pos_q  <= '0;
            lsb_q  <= '0;
            div_q  <= '0;
        end else if (abort) begin
            st_q   <= ST_IDLE;
            code_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (conv_go) begin
                    st_q  <= ST_SAMPLE;
                    div_q <= div;
                    lsb_q <= res_code;
                end
                ST_SAMPLE: if (tick) begin
                    code_q <= RES'(1) << (RES - 1);
                    pos_q  <= PW'(RES - 1);
                    st_q   <= ST_RESOLVE;
                end
                ST_RESOLVE: if (tick) begin
                    if (last_bit) begin
                        code_q <= '0;
                        st_q   <= ST_IDLE;
                    end else begin
                        code_q <= trial_nxt;
                        pos_q  <= pos_q - 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R3: bits below the resolution limit are never set in a result
    p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ((result & ((RES'(1) << lsb_q) - 1'b1)) == '0));

    // R4: the trial code only moves on a conversion clock tick
    p_dac_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !abort) |=> $stable(dac_code));
endmodule

// File: rtl/sar_conv_ctrl.sv
// SAR ADC conversion sequencer top: control/result registers, start arbitration,
// burst channel scanning and result formatting around the bit engine.
// Assumes a single-cycle register port; reads of address 1 clear the done flag.
module sar_conv_ctrl
    import sar_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic                reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic [N_TRIG-1:0]   trig_in,
    input  logic                cmp_in,
    output logic [NUM_CH-1:0]   ch_sel,
    output logic [RES_BITS-1:0] dac_code,
    output logic                busy
);
    logic [WORD_W-1:0]   ctrl_q;
    logic [NUM_CH-1:0]   sel;
    logic [DIV_W-1:0]    div;
    logic                burst;
    logic [RESC_W-1:0]   resc;
    logic                enable;
    logic [START_W-1:0]  start;
    logic                trig_fall;
    logic                wr_ctrl;
    logic                rd_gdr;
    logic                trig_fire;
    logic                go;
    logic                abort;
    logic                eng_fin;
    logic [RES_BITS-1:0] eng_res;
    logic [CH_W-1:0]     cur_ch;
    logic [CH_W-1:0]     last_ch;
    logic                done_q;
    logic [CH_W-1:0]     gch_q;
    logic [RES_BITS-1:0] gres_q;
    logic [WORD_W-1:0]   gdr_word;

    assign sel       = ctrl_q[SEL_LSB +: NUM_CH];
    assign div       = ctrl_q[DIV_LSB +: DIV_W];
    assign burst     = ctrl_q[BURST_BIT];
    assign resc      = ctrl_q[RESC_LSB +: RESC_W];
    assign enable    = ctrl_q[EN_BIT];
    assign start     = ctrl_q[START_LSB +: START_W];
    assign trig_fall = ctrl_q[FALL_BIT];

    assign wr_ctrl = reg_wr && (reg_addr == 1'b0);
    assign rd_gdr  = reg_rd && (reg_addr == 1'b1);

    sar_trigger #(.N_TRIG(N_TRIG), .START_W(START_W)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_in(trig_in),
        .mode   (start),
        .on_fall(trig_fall),
        .fire   (trig_fire)
    );

    // start arbitration: software, armed trigger, or burst continuation
    always_comb begin
        go = !busy && enable && (sel != '0) &&
             ((start == START_W'(1)) || trig_fire || (burst && start == '0));
    end
    assign abort = busy && !enable;

    sar_bit_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .conv_go (go),
        .abort   (abort),
        .div     (div),
        .res_code(resc),
        .cmp_in  (cmp_in),
        .busy    (busy),
        .dac_code(dac_code),
        .fin     (eng_fin),
        .result  (eng_res)
    );

    // control register with self-clearing start field
    always_ff @(posedge clk) begin
        if (!rst_n)                     ctrl_q <= '0;
        else if (wr_ctrl)               ctrl_q <= reg_wdata & CTRL_MASK;
        else if (go && start != '0)     ctrl_q[START_LSB +: START_W] <= '0;
    end

    // channel chosen for each conversion, scanning upward from the previous one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch  <= '0;
            last_ch <= CH_W'(NUM_CH - 1);
        end else if (wr_ctrl) begin
            last_ch <= CH_W'(NUM_CH - 1);
        end else if (go) begin
            cur_ch  <= next_chan(sel, last_ch);
            last_ch <= next_chan(sel, last_ch);
        end
    end

    // result register: capture on completion, clear done on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            gch_q  <= '0;
            gres_q <= '0;
        end else if (eng_fin) begin
            done_q <= 1'b1;
            gch_q  <= cur_ch;
            gres_q <= eng_res;
        end else if (rd_gdr) begin
            done_q <= 1'b0;
        end
    end

    // result word assembly
    always_comb begin
        gdr_word = '0;
        gdr_word[DONE_BIT] = done_q;
        gdr_word[CHF_LSB +: CH_W] = gch_q;
        gdr_word[RESF_LSB +: RES_BITS] = gres_q;
    end

    assign reg_rdata = reg_addr ? gdr_word : ctrl_q;
    assign ch_sel    = busy ? (NUM_CH'(1) << cur_ch) : '0;

    // R11: channel select never names more than one input
    p_chsel_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_sel));

    // R8: a new conversion always converts a selected channel
    p_chan_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !$past(wr_ctrl)) |-> ((ch_sel & sel) != '0));

    // R5: a completion is visible as done on the next cycle
    p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_fin |=> reg_rdata[DONE_BIT] || !reg_addr);

    // R5: reading the result word without a completion clears done
    p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gdr && !eng_fin) |=> !done_q);

    // R6: a start command clears itself once the conversion begins
    p_start_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && start != '0 && !wr_ctrl) |=> (start == '0));

    // R10: a disabled converter is idle on the next cycle
    p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy);
endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
// Bench for the SAR conversion sequencer: vector table for single conversions,
// then directed tests for triggers, burst scanning, enable and result clearing.
module sar_conv_ctrl_tb_top;
    import sar_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd, reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [5:0]  trig_in;
    logic        cmp_in;
    logic [7:0]  ch_sel;
    logic [9:0]  dac_code;
    logic        busy;
    logic [9:0]  analog;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    // comparator model: 1 when the input is at or above the trial code
    assign cmp_in = (analog >= dac_code);

    sar_conv_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trig_in(trig_in), .cmp_in(cmp_in), .ch_sel(ch_sel),
        .dac_code(dac_code), .busy(busy)
    );

    typedef struct packed {
        logic [9:0]  analog;
        logic [2:0]  rc;
        logic [7:0]  div;
        logic [7:0]  sel;
        logic [9:0]  exp_res;
        logic [2:0]  exp_ch;
        logic [15:0] exp_cyc;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{10'd1023, 3'd0, 8'd0, 8'h01, 10'd1023, 3'd0, 16'd11},
        '{10'd0,    3'd0, 8'd2, 8'h80, 10'd0,    3'd7, 16'd33},
        '{10'd677,  3'd3, 8'd1, 8'h04, 10'd672,  3'd2, 16'd16},
        '{10'd513,  3'd7, 8'd4, 8'h20, 10'd512,  3'd5, 16'd20},
        '{10'd300,  3'd1, 8'd0, 8'h08, 10'd300,  3'd3, 16'd10},
        '{10'd1022, 3'd0, 8'd3, 8'h40, 10'd1022, 3'd6, 16'd44}
    };

    // watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [7:0] sel, input logic [7:0] div,
                                            input logic burst, input logic [2:0] rc,
                                            input logic en, input logic [2:0] st,
                                            input logic fall);
        return {4'b0, fall, st, 2'b0, en, 1'b0, rc, burst, div, sel};
    endfunction

    function automatic logic [31:0] mk_gdr(input logic done, input logic [2:0] ch,
                                           input logic [9:0] res);
        return {done, 4'b0, ch, 8'b0, res, 6'b0};
    endfunction

    task automatic write_ctrl(input logic [31:0] d);
        @(negedge clk);
        reg_addr = 1'b0; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_gdr(output logic [31:0] v);
        @(negedge clk);
        reg_addr = 1'b1; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic wait_busy(input logic lvl, input int lim, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (busy == lvl) begin ok = 1'b1; break; end
        end
    endtask

    task automatic idle_for(input int k, output bit saw);
        saw = 1'b0;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (busy) saw = 1'b1;
        end
    endtask

    initial begin
        logic [31:0] v;
        bit ok, saw;
        int n;
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 1'b0;
        reg_wdata = '0; trig_in = '0; analog = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "ctrl after reset", reg_rdata, 32'h0);
        reg_addr = 1'b1; #1;
        chk("R1", "result after reset", reg_rdata, 32'h0);
        reg_addr = 1'b0;
        chk("R1", "busy/ch_sel/dac after reset", {13'b0, busy, ch_sel, dac_code}, 32'h0);

        // R2 R3 R4 R5 R6: software-started single conversions from the table
        for (int i = 0; i < NV; i++) begin
            analog = VECS[i].analog;
            write_ctrl(mk_ctrl(VECS[i].sel, VECS[i].div, 1'b0, VECS[i].rc, 1'b1, 3'd1, 1'b0));
            wait_busy(1'b1, 20, ok);
            chk("R6", "software start began", {31'b0, ok}, 32'h1);
            chk("R6", "start field cleared", {29'b0, reg_rdata[26:24]}, 32'h0);
            chk("R11", "ch_sel during conversion", {24'b0, ch_sel}, 32'(8'h01 << VECS[i].exp_ch));
            n = 1;
            for (int k = 0; k < 5000; k++) begin
                @(negedge clk);
                if (busy) n++; else break;
            end
            chk("R2", "conversion length", 32'(n), 32'(VECS[i].exp_cyc));
            read_gdr(v);
            chk("R4", "result word", v, mk_gdr(1'b1, VECS[i].exp_ch, VECS[i].exp_res));
        end

        // R5: a second read shows done cleared, fields kept
        read_gdr(v);
        chk("R5", "done cleared by read", v, mk_gdr(1'b0, 3'd6, 10'd1022));

        // R7: rising-edge trigger on input 1, falling edge ignored
        analog = 10'd777;
        trig_in[1] = 1'b1;
        @(negedge clk);
        write_ctrl(mk_ctrl(8'h02, 8'd0, 1'b0, 3'd7, 1'b1, 3'd3, 1'b0));
        repeat (2) @(negedge clk);
        trig_in[1] = 1'b0;
        idle_for(10, saw);
        chk("R7", "falling edge ignored when rising selected", {31'b0, saw}, 32'h0);
        chk("R7", "start field still armed", {29'b0, reg_rdata[26:24]}, 32'h3);
        trig_in[1] = 1'b1;
        wait_busy(1'b1, 5, ok);
        chk("R7", "rising edge started conversion", {31'b0, ok}, 32'h1);
        wait_busy(1'b0, 50, ok);
        read_gdr(v);
        chk("R7", "triggered result", v, mk_gdr(1'b1, 3'd1, 10'd768));

        // R7: falling-edge trigger on input 5, rising edge ignored
        analog = 10'd100;
        write_ctrl(mk_ctrl(8'h10, 8'd1, 1'b0, 3'd0, 1'b1, 3'd7, 1'b1));
        trig_in[5] = 1'b1;
        idle_for(10, saw);
        chk("R7", "rising edge ignored when falling selected", {31'b0, saw}, 32'h0);
        trig_in[5] = 1'b0;
        wait_busy(1'b1, 5, ok);
        chk("R7", "falling edge started conversion", {31'b0, ok}, 32'h1);
        wait_busy(1'b0, 100, ok);
        read_gdr(v);
        chk("R7", "falling-trigger result", v, mk_gdr(1'b1, 3'd4, 10'd100));

        // R8: burst scan over channels 0, 2, 4 with wrap
        write_ctrl(mk_ctrl(8'h15, 8'd0, 1'b1, 3'd7, 1'b1, 3'd0, 1'b0));
        for (int j = 0; j < 4; j++) begin
            wait_busy(1'b1, 20, ok);
            chk("R8", "burst channel order", {24'b0, ch_sel},
                32'(j == 1 ? 8'h04 : (j == 2 ? 8'h10 : 8'h01)));
            if (j < 3) wait_busy(1'b0, 20, ok);
        end
        read_gdr(v);
        chk("R8", "burst last completed channel", {29'b0, v[26:24]}, 32'h4);

        // R9: burst with a non-zero start field runs nothing
        write_ctrl(mk_ctrl(8'h01, 8'd0, 1'b1, 3'd7, 1'b0, 3'd0, 1'b0));
        write_ctrl(mk_ctrl(8'h01, 8'd0, 1'b1, 3'd7, 1'b1, 3'd2, 1'b0));
        idle_for(40, saw);
        chk("R9", "no burst while start field non-zero", {31'b0, saw}, 32'h0);

        // R10: disabled converter keeps a pending software start
        write_ctrl(mk_ctrl(8'h01, 8'd0, 1'b0, 3'd0, 1'b0, 3'd1, 1'b0));
        idle_for(20, saw);
        chk("R10", "disabled stays idle", {31'b0, saw}, 32'h0);
        chk("R10", "pending start kept", {29'b0, reg_rdata[26:24]}, 32'h1);

        // R10: disabling mid-conversion abandons it without done
        read_gdr(v);
        write_ctrl(mk_ctrl(8'h01, 8'd20, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        wait_busy(1'b1, 10, ok);
        repeat (10) @(negedge clk);
        write_ctrl(mk_ctrl(8'h01, 8'd20, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0));
        @(negedge clk);
        chk("R10", "aborted conversion idle", {31'b0, busy}, 32'h0);
        idle_for(300, saw);
        read_gdr(v);
        chk("R10", "no done after abort", {31'b0, v[31]}, 32'h0);

        // R11: channel select idle after all activity
        chk("R11", "ch_sel idle", {24'b0, ch_sel}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule